// File: doc/BRIEF.md
# I2C Slave Address Recogniser

This block decides whether an I2C transfer is meant for this node. A bit-level receiver upstream reports each START or repeated START and hands over every received byte with a one-cycle valid strobe. The first byte after a START is compared with the node's own 7-bit address and, when the option is built in and switched on at run time, with the all-zero general-call address. The result is presented as registered flags: a hit flag, a general-call flag, the captured transfer direction and the acknowledge decision that the bus logic drives onto the wire.

The block keeps recognising addresses while the system sleeps. An acknowledged match taken in sleep raises a wake request, which holds until the system leaves sleep. If a different wake source fires while the system is still asleep, the pending recognition is dropped: all flags clear and the block waits for the next START. Data bytes never trigger a comparison; after a NACK the block ignores traffic until a new START.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0.
- R2: In the cycle after a byte strobe that is the first byte after a START, when byte bits [7:1] equal the own address, `addr_hit` is 1 and `rw_dir` takes byte bit 0 (1 = read, 0 = write).
- R3: When the first byte matches neither the own address nor an accepted general call, `addr_hit`, `gc_hit` and `ack_out` are 0 in the next cycle.
- R4: With general-call support built in and `gc_en` = 1, a first byte of 0x00 gives `addr_hit` = 1 and `gc_hit` = 1; with `gc_en` = 0 the same byte gives no hit (unless the own address is 0).
- R5: A first byte of 0x01 (all-zero address with the read bit) is never a general call; `gc_hit` stays 0.
- R6: `ack_out` is 1 only when the byte hit and `ack_en` was 1 in the cycle of the strobe; a hit with `ack_en` = 0 gives `addr_hit` = 1 and `ack_out` = 0.
- R7: Bytes strobed after the first byte, including all bytes after a NACK, leave every output unchanged.
- R8: In the cycle after `start_det`, every output is 0 and the next byte strobe is treated as an address byte.
- R9: An acknowledged hit while `sleep_mode` = 1 sets `wake_req` in the next cycle; it holds while `sleep_mode` stays 1 and clears in the cycle after `sleep_mode` falls.
- R10: When `sleep_mode` and `other_wake` are both 1, all outputs are 0 in the next cycle and later byte strobes are ignored until the next START.
- R11: A byte strobe in the same cycle as `start_det` is ignored; the following strobe is the address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_det | input | 1 | One-cycle pulse on START or repeated START |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | ADDR_W+1 | Received byte; bit 0 is the direction bit |
| own_addr | input | ADDR_W | Node's own slave address |
| gc_en | input | 1 | Run-time enable for general-call recognition |
| ack_en | input | 1 | Allow acknowledging a recognised address |
| sleep_mode | input | 1 | System is in a low-power state |
| other_wake | input | 1 | Another wake source has fired |
| addr_hit | output | 1 | Address byte was recognised |
| gc_hit | output | 1 | Recognised byte was a general call |
| rw_dir | output | 1 | Captured direction, 1 = read |
| ack_out | output | 1 | Acknowledge decision for the address byte |
| wake_req | output | 1 | Wake request from a match taken in sleep |

## Verification
The bench builds the block with its defaults: a 7-bit address and general-call support compiled in, so both the own-address path and the all-zero path, with its run-time enable and its read-bit refusal, are reachable. A behavioural model follows every cycle, while directed sequences walk through repeated STARTs, NACK lockout, a START colliding with a byte strobe, and the sleep wake and abort paths.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
   typedef enum logic [1:0] {
      AM_IDLE  = 2'd0,
      AM_ARMED = 2'd1,
      AM_HELD  = 2'd2
   } am_state_t;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
   parameter int ADDR_W    = 7,
   parameter bit GC_ENABLE = 1'b1
) (
   input  logic [ADDR_W:0]   addr_byte,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   output logic              own_hit,
   output logic              gc_hit
);
   localparam int BYTE_W = ADDR_W + 1;

   assign own_hit = (addr_byte[ADDR_W:1] == own_addr);

   generate
      if (GC_ENABLE) begin : g_gc
         // all-zero address with the write direction only
         assign gc_hit = gc_en && (addr_byte == {BYTE_W{1'b0}});
      end else begin : g_no_gc
         logic gc_en_unused;
         assign gc_en_unused = gc_en;
         assign gc_hit       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
   import i2c_am_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_det,
   input  logic byte_vld,
   input  logic rw_bit,
   input  logic own_hit,
   input  logic gc_hit_in,
   input  logic ack_en,
   input  logic sleep_mode,
   input  logic other_wake,
   output logic addr_hit,
   output logic gc_hit,
   output logic rw_dir,
   output logic ack_out,
   output logic wake_req
);
   am_state_t state;
   logic      any_hit;
   logic      abort;

   assign any_hit = own_hit | gc_hit_in;
   assign abort   = sleep_mode & other_wake;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= AM_IDLE;
         addr_hit <= 1'b0;
         gc_hit   <= 1'b0;
         rw_dir   <= 1'b0;
         ack_out  <= 1'b0;
         wake_req <= 1'b0;
      end else if (abort) begin
         state    <= AM_IDLE;
         addr_hit <= 1'b0;
         gc_hit   <= 1'b0;
         rw_dir   <= 1'b0;
         ack_out  <= 1'b0;
         wake_req <= 1'b0;
      end else if (start_det) begin
         state    <= AM_ARMED;
         addr_hit <= 1'b0;
         gc_hit   <= 1'b0;
         rw_dir   <= 1'b0;
         ack_out  <= 1'b0;
         wake_req <= 1'b0;
      end else begin
         case (state)
            AM_ARMED: begin
               if (byte_vld) begin
                  addr_hit <= any_hit;
                  gc_hit   <= gc_hit_in;
                  rw_dir   <= any_hit & rw_bit;
                  ack_out  <= any_hit & ack_en;
                  wake_req <= any_hit & ack_en & sleep_mode;
                  state    <= (any_hit && ack_en) ? AM_HELD : AM_IDLE;
               end
            end
            AM_HELD: wake_req <= wake_req & sleep_mode;
            default: state <= AM_IDLE;
         endcase
      end
   end

   // R6
   ack_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out |-> addr_hit);

   // R5
   gc_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gc_hit |-> (addr_hit && !rw_dir));

   // R9
   wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(sleep_mode) && ack_out));

   // R8
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !abort) |=> (!addr_hit && !gc_hit && !ack_out && !wake_req && !rw_dir));

   // R10
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!addr_hit && !gc_hit && !ack_out && !wake_req));

   // R7
   data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != AM_ARMED && !start_det && !abort && !sleep_mode)
      |=> ($stable(addr_hit) && $stable(gc_hit) && $stable(rw_dir) && $stable(ack_out)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
   parameter int ADDR_W    = 7,
   parameter bit GC_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              byte_vld,
   input  logic [ADDR_W:0]   byte_data,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   input  logic              ack_en,
   input  logic              sleep_mode,
   input  logic              other_wake,
   output logic              addr_hit,
   output logic              gc_hit,
   output logic              rw_dir,
   output logic              ack_out,
   output logic              wake_req
);
   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
         $error("i2c_addr_match: ADDR_W must be 1..10");
      end
   endgenerate

   logic own_hit;
   logic gc_raw;

   i2c_am_cmp #(
      .ADDR_W    (ADDR_W),
      .GC_ENABLE (GC_ENABLE)
   ) u_cmp (
      .addr_byte (byte_data),
      .own_addr  (own_addr),
      .gc_en     (gc_en),
      .own_hit   (own_hit),
      .gc_hit    (gc_raw)
   );

   i2c_am_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_det  (start_det),
      .byte_vld   (byte_vld),
      .rw_bit     (byte_data[0]),
      .own_hit    (own_hit),
      .gc_hit_in  (gc_raw),
      .ack_en     (ack_en),
      .sleep_mode (sleep_mode),
      .other_wake (other_wake),
      .addr_hit   (addr_hit),
      .gc_hit     (gc_hit),
      .rw_dir     (rw_dir),
      .ack_out    (ack_out),
      .wake_req   (wake_req)
   );
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_det = 1'b0, byte_vld = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [6:0] own_addr = 7'h2A;
   logic       gc_en = 1'b1, ack_en = 1'b1, sleep_mode = 1'b0, other_wake = 1'b0;
   logic       addr_hit, gc_hit, rw_dir, ack_out, wake_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_addr_match u_dut (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
      .byte_data(byte_data), .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en),
      .sleep_mode(sleep_mode), .other_wake(other_wake), .addr_hit(addr_hit),
      .gc_hit(gc_hit), .rw_dir(rw_dir), .ack_out(ack_out), .wake_req(wake_req)
   );

   // behavioural reference: phase 0 idle, 1 waiting for address, 2 holding
   int m_phase = 0;
   bit m_hit = 0, m_gc = 0, m_rw = 0, m_ack = 0, m_wake = 0;

   always @(posedge clk) begin
      if (!rst_n || (sleep_mode && other_wake) || start_det) begin
         m_phase = (rst_n && !(sleep_mode && other_wake)) ? 1 : 0;
         m_hit = 0; m_gc = 0; m_rw = 0; m_ack = 0; m_wake = 0;
      end else if (m_phase == 1 && byte_vld) begin
         bit mine, gen;
         mine   = (int'(byte_data) / 2) == int'(own_addr);
         gen    = gc_en && (int'(byte_data) == 0);
         m_hit  = mine || gen;
         m_gc   = gen;
         m_rw   = m_hit && (int'(byte_data) % 2 == 1);
         m_ack  = m_hit && ack_en;
         m_wake = m_ack && sleep_mode;
         m_phase = m_ack ? 2 : 0;
      end else if (m_phase == 2 && !sleep_mode) begin
         m_wake = 0;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if ({addr_hit, gc_hit, rw_dir, ack_out, wake_req} !== {m_hit, m_gc, m_rw, m_ack, m_wake}) begin
            errors++;
            $display("FAIL MODEL t=%0t actual=%b expected=%b", $time,
                     {addr_hit, gc_hit, rw_dir, ack_out, wake_req},
                     {m_hit, m_gc, m_rw, m_ack, m_wake});
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic v, input logic [7:0] b);
      start_det = s; byte_vld = v; byte_data = b;
      @(negedge clk);
      start_det = 1'b0; byte_vld = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(addr_hit | gc_hit | rw_dir | ack_out | wake_req, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(addr_hit | ack_out | wake_req, 1'b0, "R1 after reset");

      cyc(1, 0, 8'h00);
      cyc(0, 1, {7'h2A, 1'b1});
      chk(addr_hit, 1'b1, "R2 hit");
      chk(rw_dir, 1'b1, "R2 read dir");
      chk(ack_out, 1'b1, "R6 ack");
      cyc(0, 1, {7'h2A, 1'b0});
      chk(rw_dir, 1'b1, "R7 data byte ignored");

      cyc(1, 0, 8'h00);
      chk(addr_hit | ack_out, 1'b0, "R8 start clears");
      cyc(0, 1, {7'h2B, 1'b0});
      chk(addr_hit, 1'b0, "R3 mismatch hit");
      chk(ack_out, 1'b0, "R3 mismatch nack");
      cyc(0, 1, {7'h2A, 1'b0});
      chk(addr_hit, 1'b0, "R7 after nack");

      cyc(1, 0, 8'h00);
      cyc(0, 1, 8'h00);
      chk(gc_hit, 1'b1, "R4 general call");
      chk(addr_hit, 1'b1, "R4 general call hit");
      cyc(1, 0, 8'h00);
      cyc(0, 1, 8'h01);
      chk(gc_hit | addr_hit, 1'b0, "R5 read general call");
      gc_en = 1'b0;
      cyc(1, 0, 8'h00);
      cyc(0, 1, 8'h00);
      chk(addr_hit, 1'b0, "R4 gc disabled");
      gc_en = 1'b1;

      ack_en = 1'b0;
      cyc(1, 0, 8'h00);
      cyc(0, 1, {7'h2A, 1'b0});
      chk(addr_hit, 1'b1, "R6 hit without ack");
      chk(ack_out, 1'b0, "R6 nack");
      ack_en = 1'b1;

      cyc(1, 1, {7'h2A, 1'b1});
      chk(addr_hit, 1'b0, "R11 colliding byte");
      cyc(0, 1, {7'h2A, 1'b0});
      chk(addr_hit, 1'b1, "R11 next byte");
      chk(rw_dir, 1'b0, "R2 write dir");

      sleep_mode = 1'b1;
      cyc(1, 0, 8'h00);
      cyc(0, 1, {7'h2A, 1'b0});
      chk(wake_req, 1'b1, "R9 wake");
      cyc(0, 0, 8'h00);
      chk(wake_req, 1'b1, "R9 wake held");
      sleep_mode = 1'b0;
      cyc(0, 0, 8'h00);
      chk(wake_req, 1'b0, "R9 wake cleared");

      sleep_mode = 1'b1;
      cyc(1, 0, 8'h00);
      cyc(0, 1, {7'h2A, 1'b0});
      other_wake = 1'b1;
      cyc(0, 0, 8'h00);
      other_wake = 1'b0;
      chk(addr_hit | ack_out | wake_req, 1'b0, "R10 abort");
      cyc(0, 1, {7'h2A, 1'b0});
      chk(addr_hit, 1'b0, "R10 idle after abort");
      sleep_mode = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule